// File: doc/BRIEF.md
# Spatio-temporal Gradient Tensor Smoother

This block takes a stream of averaged image gradients, one triple (horizontal, vertical and temporal gradient) per accepted pixel in raster order, and turns each pixel into the six distinct entries of the symmetric 3x3 outer-product matrix of that triple. Each of the six entry planes is then smoothed over a 3x3 neighbourhood with near-Gaussian integer weights. The 2D smoothing is split into a 3-tap pass along the row followed by a 3-tap pass down the column, which runs through two line buffers per entry. The six smoothed sums are shifted right by a common amount and clamped to a narrow signed width. A common scale on all six entries cancels in the later flow solve, so the shift also absorbs the kernel normalisation.

A frame is `IMG_H` rows of `IMG_W` pixels. Positions are tracked by counters that advance only on accepted inputs, so the stream may contain idle cycles anywhere. Each smoothed result needs one pixel to its right and one row below it. A result is therefore released when a later input arrives, and the last row of a frame comes out while the first row of the next frame streams in.

Top module: `tensor_smooth`

## Requirements
- R1: While reset is asserted, and after it until the first result, `outValid` is 0 and all six tensor outputs are 0.
- R2: Output channels carry, in this order, gx·gx, gy·gy, gt·gt, gx·gy, gx·gt and gy·gt of the smoothed neighbourhood (gx = `gradX`, gy = `gradY`, gt = `gradT`, all two's complement).
- R3: The row pass forms side·p[c-1] + centre·p[c] + side·p[c+1] with side weight `W_SIDE` (default 12) and centre weight `W_CENTRE` (default 13). Neighbours left of column 0 or right of column `IMG_W`-1 contribute zero.
- R4: The column pass applies the same weights to row-pass sums of rows r-1, r and r+1 of the same frame. Rows above row 0 or below row `IMG_H`-1 contribute zero.
- R5: Each output is the column-pass sum arithmetically shifted right by `SHIFT` (default 8), then clamped to the signed `OW`-bit range (default -32768 to 32767).
- R6: The result for stream pixel m appears with `outValid` high for one cycle, after the fourth rising edge following the edge that accepted stream pixel m+`IMG_W`+1. Once primed, exactly one result appears per accepted input.
- R7: Cycles with `inValid` low are ignored: the gradient values on those cycles have no effect, and results equal those of the same pixels sent without gaps.
- R8: Column and row positions wrap to (0,0) after the last pixel of a frame. The last row of a frame is released during the next frame's first row, and data of the next frame contributes nothing to it.
- R9: The first `IMG_W`+1 accepted inputs after reset produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Gradient triple on this cycle is accepted |
| gradX | input | GW | Signed horizontal gradient |
| gradY | input | GW | Signed vertical gradient |
| gradT | input | GW | Signed temporal gradient |
| outValid | output | 1 | Six tensor outputs hold a new result |
| tensXX | output | OW | Smoothed gx·gx |
| tensYY | output | OW | Smoothed gy·gy |
| tensTT | output | OW | Smoothed gt·gt |
| tensXY | output | OW | Smoothed gx·gy |
| tensXT | output | OW | Smoothed gx·gt |
| tensYT | output | OW | Smoothed gy·gt |

## Verification
A frame of full-range pseudo-random gradients exercises the channel mapping and the signed products. A constant frame gives equal interior results, so any deviation at the border shows whether the edge zeroing in the row and column passes is right. A single-pixel impulse maps the nine weights onto nine distinct output positions, which catches swapped side and centre weights and a transposed pass. An extreme-value frame drives every channel into positive or negative clamping. A frame sent with idle cycles carrying junk values must give the same results as a dense stream. Each result is compared with a behavioural model on the exact cycle it is due, and silent cycles are checked as well, so a wrong latency, wrong priming, or leakage across the frame seam shows up even when the values are right.

// File: rtl/tsm_pkg.sv
package tsm_pkg;

  localparam int NCOMP = 6;

  // Per-stage strobes issued by the control module to the datapath
  typedef struct packed {
    logic loadIn;    // capture products of an accepted gradient triple
    logic shiftWin;  // shift the 3-tap row window
    logic loadH;     // register the row-pass sum for the window centre
    logic maskL;     // centre sits in column 0
    logic maskR;     // centre sits in the last column
    logic loadV;     // line-buffer access and column-pass register
    logic maskU;     // column-pass centre sits in row 0
    logic maskD;     // column-pass centre sits in the last row
    logic loadOut;   // register the trimmed result
  } tsmStrobe_t;

endpackage

// File: rtl/tensor_smooth_ctrl.sv
module tensor_smooth_ctrl
  import tsm_pkg::*;
#(
  parameter int IMG_W = 64,
  parameter int IMG_H = 48,
  parameter int COLW  = 6,
  parameter int ROWW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  output tsmStrobe_t       stb,
  output logic [COLW-1:0]  lbAddr,
  output logic             outValid
);

  localparam logic [COLW-1:0] LAST_COL = COLW'(IMG_W - 1);
  localparam logic [ROWW-1:0] LAST_ROW = ROWW'(IMG_H - 1);

  logic [COLW-1:0] inCol, c1, prevCol, c2, c3;
  logic [ROWW-1:0] inRow, r1, prevRow, r2, r3;
  logic            v1, v2, v3, v4;
  logic            hPrimed, vPrimed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inCol    <= '0;
      inRow    <= '0;
      c1       <= '0;
      r1       <= '0;
      v1       <= 1'b0;
      prevCol  <= '0;
      prevRow  <= '0;
      hPrimed  <= 1'b0;
      v2       <= 1'b0;
      c2       <= '0;
      r2       <= '0;
      v3       <= 1'b0;
      c3       <= '0;
      r3       <= '0;
      vPrimed  <= 1'b0;
      v4       <= 1'b0;
      outValid <= 1'b0;
    end else begin
      // raster position of the incoming pixel
      if (inValid) begin
        if (inCol == LAST_COL) begin
          inCol <= '0;
          inRow <= (inRow == LAST_ROW) ? '0 : inRow + 1'b1;
        end else begin
          inCol <= inCol + 1'b1;
        end
      end
      // product stage
      v1 <= inValid;
      c1 <= inCol;
      r1 <= inRow;
      // row window: centre is the pixel shifted in one step earlier
      if (v1) begin
        hPrimed <= 1'b1;
        prevCol <= c1;
        prevRow <= r1;
      end
      v2 <= v1 && hPrimed;
      c2 <= prevCol;
      r2 <= prevRow;
      // row-pass result stage
      v3 <= v2;
      c3 <= c2;
      r3 <= r2;
      // column pass needs a full previous row of row-pass sums
      if (v3 && (c3 == LAST_COL)) vPrimed <= 1'b1;
      v4       <= v3 && vPrimed;
      outValid <= v4;
    end
  end

  always_comb begin
    stb.loadIn   = inValid;
    stb.shiftWin = v1;
    stb.loadH    = v2;
    stb.maskL    = (c2 == '0);
    stb.maskR    = (c2 == LAST_COL);
    stb.loadV    = v3;
    stb.maskU    = (r3 == ROWW'(1));  // centre row is the row before r3
    stb.maskD    = (r3 == '0);        // centre row is the previous frame's last
    stb.loadOut  = v4;
    lbAddr       = c3;
  end

  // R6: every result traces back to an input accepted five edges before
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid, 5));

  // R8: the position wraps to the frame origin after the last pixel
  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inCol == LAST_COL && inRow == LAST_ROW) |=> (inCol == '0 && inRow == '0));

  // R7: idle cycles leave the raster position untouched
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(inCol) && $stable(inRow)));

  // R9: no column-pass output before the first row is complete
  assert_prime_R9: assert property (@(posedge clk) disable iff (!rst_n)
    v4 |-> $past(vPrimed));

endmodule

// File: rtl/tensor_smooth_lane.sv
module tensor_smooth_lane #(
  parameter int PW       = 16,
  parameter int TAP_BITS = 5,
  parameter int W_SIDE   = 12,
  parameter int W_CENTRE = 13,
  parameter int IMG_W    = 64,
  parameter int COLW     = 6,
  parameter int OW       = 16,
  parameter int SHIFT    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shiftWin,
  input  logic                 loadH,
  input  logic                 maskL,
  input  logic                 maskR,
  input  logic                 loadV,
  input  logic                 maskU,
  input  logic                 maskD,
  input  logic                 loadOut,
  input  logic [COLW-1:0]      lbAddr,
  input  logic signed [PW-1:0] prodIn,
  output logic signed [OW-1:0] tOut
);

  localparam int HW = PW + TAP_BITS + 2;
  localparam int VW = HW + TAP_BITS + 2;
  localparam logic signed [HW-1:0] KH_SIDE   = HW'(W_SIDE);
  localparam logic signed [HW-1:0] KH_CENTRE = HW'(W_CENTRE);
  localparam logic signed [VW-1:0] KV_SIDE   = VW'(W_SIDE);
  localparam logic signed [VW-1:0] KV_CENTRE = VW'(W_CENTRE);
  localparam logic signed [VW-1:0] SAT_HI    = VW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [VW-1:0] SAT_LO    = ~SAT_HI;

  logic signed [PW-1:0] win0, win1, win2;
  logic signed [HW-1:0] hl, hc, hr, hSum, hReg;
  logic signed [HW-1:0] lbA [IMG_W];
  logic signed [HW-1:0] lbB [IMG_W];
  logic signed [HW-1:0] rdA, rdB;
  logic signed [VW-1:0] vu, vc, vd, vSum, vReg, shifted;
  logic signed [OW-1:0] trimmed;

  // row pass: win2 = left, win1 = centre, win0 = right
  always_comb begin
    hl = '0;
    hr = '0;
    if (!maskL) hl = HW'(win2);
    if (!maskR) hr = HW'(win0);
    hc   = HW'(win1);
    hSum = hl * KH_SIDE + hc * KH_CENTRE + hr * KH_SIDE;
  end

  // column pass: lbB = two rows back, lbA = one row back, hReg = current row
  always_comb begin
    rdA = lbA[lbAddr];
    rdB = lbB[lbAddr];
    vu  = '0;
    vd  = '0;
    if (!maskU) vu = VW'(rdB);
    if (!maskD) vd = VW'(hReg);
    vc   = VW'(rdA);
    vSum = vu * KV_SIDE + vc * KV_CENTRE + vd * KV_SIDE;
  end

  always_comb begin
    shifted = vReg >>> SHIFT;
    if (shifted > SAT_HI)      trimmed = SAT_HI[OW-1:0];
    else if (shifted < SAT_LO) trimmed = SAT_LO[OW-1:0];
    else                       trimmed = shifted[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (shiftWin) begin
      win0 <= prodIn;
      win1 <= win0;
      win2 <= win1;
    end
    if (loadH) hReg <= hSum;
    if (loadV) begin
      lbB[lbAddr] <= rdA;
      lbA[lbAddr] <= hReg;
      vReg        <= vSum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tOut <= '0;
    else if (loadOut) tOut <= trimmed;
  end

  // R5: sums beyond the output range clamp at the positive limit
  assert_no_overflow_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loadOut && (vReg >>> SHIFT) > SAT_HI) |=> (tOut == SAT_HI[OW-1:0]));

  // R5: and at the negative limit
  assert_no_overflow_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (loadOut && (vReg >>> SHIFT) < SAT_LO) |=> (tOut == SAT_LO[OW-1:0]));

  // R1: output holds between results
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !loadOut |=> $stable(tOut));

endmodule

// File: rtl/tensor_smooth_dp.sv
module tensor_smooth_dp
  import tsm_pkg::*;
#(
  parameter int GW       = 8,
  parameter int TAP_BITS = 5,
  parameter int W_SIDE   = 12,
  parameter int W_CENTRE = 13,
  parameter int IMG_W    = 64,
  parameter int COLW     = 6,
  parameter int OW       = 16,
  parameter int SHIFT    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  tsmStrobe_t           stb,
  input  logic [COLW-1:0]      lbAddr,
  input  logic signed [GW-1:0] gx,
  input  logic signed [GW-1:0] gy,
  input  logic signed [GW-1:0] gt,
  output logic signed [OW-1:0] tOut [NCOMP]
);

  localparam int PW = 2 * GW;

  logic signed [PW-1:0] prodC [NCOMP];
  logic signed [PW-1:0] prodR [NCOMP];

  // channel order: xx, yy, tt, xy, xt, yt
  always_comb begin
    prodC[0] = PW'(gx) * PW'(gx);
    prodC[1] = PW'(gy) * PW'(gy);
    prodC[2] = PW'(gt) * PW'(gt);
    prodC[3] = PW'(gx) * PW'(gy);
    prodC[4] = PW'(gx) * PW'(gt);
    prodC[5] = PW'(gy) * PW'(gt);
  end

  always_ff @(posedge clk) begin
    if (stb.loadIn) prodR <= prodC;
  end

  for (genvar k = 0; k < NCOMP; k++) begin : g_lane
    tensor_smooth_lane #(
      .PW(PW), .TAP_BITS(TAP_BITS), .W_SIDE(W_SIDE), .W_CENTRE(W_CENTRE),
      .IMG_W(IMG_W), .COLW(COLW), .OW(OW), .SHIFT(SHIFT)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .shiftWin(stb.shiftWin),
      .loadH   (stb.loadH),
      .maskL   (stb.maskL),
      .maskR   (stb.maskR),
      .loadV   (stb.loadV),
      .maskU   (stb.maskU),
      .maskD   (stb.maskD),
      .loadOut (stb.loadOut),
      .lbAddr  (lbAddr),
      .prodIn  (prodR[k]),
      .tOut    (tOut[k])
    );
  end

  // R2: the three square channels never carry a negative product
  assert_square_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.loadIn |=> (!prodR[0][PW-1] && !prodR[1][PW-1] && !prodR[2][PW-1]));

endmodule

// File: rtl/tensor_smooth.sv
module tensor_smooth
  import tsm_pkg::*;
#(
  parameter int GW       = 8,
  parameter int IMG_W    = 64,
  parameter int IMG_H    = 48,
  parameter int TAP_BITS = 5,
  parameter int W_SIDE   = 12,
  parameter int W_CENTRE = 13,
  parameter int OW       = 16,
  parameter int SHIFT    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic signed [GW-1:0] gradX,
  input  logic signed [GW-1:0] gradY,
  input  logic signed [GW-1:0] gradT,
  output logic                 outValid,
  output logic signed [OW-1:0] tensXX,
  output logic signed [OW-1:0] tensYY,
  output logic signed [OW-1:0] tensTT,
  output logic signed [OW-1:0] tensXY,
  output logic signed [OW-1:0] tensXT,
  output logic signed [OW-1:0] tensYT
);

  localparam int COLW = (IMG_W > 1) ? $clog2(IMG_W) : 1;
  localparam int ROWW = (IMG_H > 2) ? $clog2(IMG_H) : 2;

  tsmStrobe_t           stb;
  logic [COLW-1:0]      lbAddr;
  logic signed [OW-1:0] tOut [NCOMP];

  tensor_smooth_ctrl #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .COLW(COLW), .ROWW(ROWW)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .stb     (stb),
    .lbAddr  (lbAddr),
    .outValid(outValid)
  );

  tensor_smooth_dp #(
    .GW(GW), .TAP_BITS(TAP_BITS), .W_SIDE(W_SIDE), .W_CENTRE(W_CENTRE),
    .IMG_W(IMG_W), .COLW(COLW), .OW(OW), .SHIFT(SHIFT)
  ) u_dp (
    .clk   (clk),
    .rst_n (rst_n),
    .stb   (stb),
    .lbAddr(lbAddr),
    .gx    (gradX),
    .gy    (gradY),
    .gt    (gradT),
    .tOut  (tOut)
  );

  assign tensXX = tOut[0];
  assign tensYY = tOut[1];
  assign tensTT = tOut[2];
  assign tensXY = tOut[3];
  assign tensXT = tOut[4];
  assign tensYT = tOut[5];

endmodule

// File: tb/tensor_smooth_bench.sv
module tensor_smooth_bench;

  localparam int TW = 6;
  localparam int TH = 4;
  localparam int NF = 5;  // full test frames; frame NF is a short flush frame

  typedef struct packed {
    int                       due;
    logic signed [5:0][63:0]  v;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic signed [7:0] gradX = '0, gradY = '0, gradT = '0;
  logic outValid;
  logic signed [15:0] tensXX, tensYY, tensTT, tensXY, tensXT, tensYT;
  logic signed [15:0] gotV [6];

  int gxA [NF+1][TH][TW];
  int gyA [NF+1][TH][TW];
  int gtA [NF+1][TH][TW];

  exp_t  qExp [$];
  string qTag [$];
  exp_t  curE;
  string curT;
  int    bad;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int driven = 0;
  int curFrame = 0;
  bit checkOn = 1'b0;
  bit done = 1'b0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tensor_smooth #(.IMG_W(TW), .IMG_H(TH)) u_tensor_smooth (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .gradX(gradX), .gradY(gradY), .gradT(gradT),
    .outValid(outValid),
    .tensXX(tensXX), .tensYY(tensYY), .tensTT(tensTT),
    .tensXY(tensXY), .tensXT(tensXT), .tensYT(tensYT)
  );

  assign gotV[0] = tensXX;
  assign gotV[1] = tensYY;
  assign gotV[2] = tensTT;
  assign gotV[3] = tensXY;
  assign gotV[4] = tensXT;
  assign gotV[5] = tensYT;

  function automatic int nextRand();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 16) & 32'h7fff);
  endfunction

  // ---------- behavioural reference ----------
  function automatic longint prodAt(int f, int r, int c, int k);
    longint a, b, t;
    if (r < 0 || r >= TH || c < 0 || c >= TW) return 0;
    a = gxA[f][r][c];
    b = gyA[f][r][c];
    t = gtA[f][r][c];
    case (k)
      0: return a * a;
      1: return b * b;
      2: return t * t;
      3: return a * b;
      4: return a * t;
      default: return b * t;
    endcase
  endfunction

  function automatic longint rowSum(int f, int r, int c, int k);
    if (r < 0 || r >= TH) return 0;
    return 12 * prodAt(f, r, c - 1, k) + 13 * prodAt(f, r, c, k) + 12 * prodAt(f, r, c + 1, k);
  endfunction

  function automatic longint expVal(int f, int r, int c, int k);
    longint s;
    s = 12 * rowSum(f, r - 1, c, k) + 13 * rowSum(f, r, c, k) + 12 * rowSum(f, r + 1, c, k);
    s = s >>> 8;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic string tagFor(int f, int r, int c);
    if (f == 2) return "R5";
    if (f == 3) return "R7";
    if (f == 4) return (r == 0 || r == TH - 1) ? "R4" : "R3";
    if (f == 1) return (c == 0 || c == TW - 1) ? "R3" : "R4";
    if (r == TH - 1) return "R8";
    return "R2";
  endfunction

  function automatic string quietTag();
    if (!rst_n || driven == 0) return "R1";
    if (driven < TW + 2) return "R9";
    if (curFrame == 3) return "R7";
    return "R6";
  endfunction

  // ---------- per-cycle comparison ----------
  always @(negedge clk) begin
    if (checkOn) begin
      if (qExp.size() > 0 && qExp[0].due == cyc) begin
        curE = qExp.pop_front();
        curT = qTag.pop_front();
        checks++;
        bad = 0;
        if (outValid !== 1'b1) begin
          $display("FAIL %s outValid got %b expected 1 (R6) at cycle %0d", curT, outValid, cyc);
          bad = 1;
        end else begin
          for (int k = 0; k < 6; k++) begin
            if (longint'(gotV[k]) != longint'($signed(curE.v[k]))) begin
              $display("FAIL %s channel %0d (R2) got %0d expected %0d at cycle %0d",
                       curT, k, gotV[k], $signed(curE.v[k]), cyc);
              bad = 1;
            end
          end
        end
        if (bad != 0) fails++;
      end else begin
        checks++;
        if (outValid !== 1'b0) begin
          fails++;
          $display("FAIL %s outValid got %b expected 0 at cycle %0d", quietTag(), outValid, cyc);
        end
      end
    end
  end

  task automatic drivePix(input int f, input int r, input int c);
    int m, mf, rem;
    exp_t e;
    if (f == 3) begin
      // R7: idle cycles carrying junk gradients
      for (int g = nextRand() % 3; g > 0; g--) begin
        @(negedge clk);
        inValid = 1'b0;
        gradX = 8'(nextRand());
        gradY = 8'(nextRand());
        gradT = 8'(nextRand());
      end
    end
    @(negedge clk);
    curFrame = f;
    inValid = 1'b1;
    gradX = 8'(gxA[f][r][c]);
    gradY = 8'(gyA[f][r][c]);
    gradT = 8'(gtA[f][r][c]);
    if (driven >= TW + 1) begin
      m   = driven - TW - 1;
      mf  = m / (TW * TH);
      rem = m % (TW * TH);
      e.due = cyc + 5;  // accepted at the next edge, four register stages later
      for (int k = 0; k < 6; k++) e.v[k] = 64'(expVal(mf, rem / TW, rem % TW, k));
      qExp.push_back(e);
      qTag.push_back(tagFor(mf, rem / TW, rem % TW));
    end
    driven++;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: got no finish, expected completion");
      finishRun();
    end
  end

  initial begin
    // stimulus frames
    for (int r = 0; r < TH; r++) begin
      for (int c = 0; c < TW; c++) begin
        gxA[0][r][c] = (nextRand() % 256) - 128;   // full-range random (R2)
        gyA[0][r][c] = (nextRand() % 256) - 128;
        gtA[0][r][c] = (nextRand() % 256) - 128;
        gxA[1][r][c] = 3;                          // constant plane (R3, R4)
        gyA[1][r][c] = -2;
        gtA[1][r][c] = 5;
        gxA[2][r][c] = 127;                        // clamping (R5)
        gyA[2][r][c] = -128;
        gtA[2][r][c] = -128;
        gxA[3][r][c] = (nextRand() % 64) - 32;     // gapped stream (R7)
        gyA[3][r][c] = (nextRand() % 64) - 32;
        gtA[3][r][c] = (nextRand() % 64) - 32;
        gxA[4][r][c] = (r == 1 && c == 2) ? 10 : 0; // impulse (R3, R4)
        gyA[4][r][c] = (r == 1 && c == 2) ? -7 : 0;
        gtA[4][r][c] = (r == 1 && c == 2) ? 4 : 0;
        gxA[NF][r][c] = 0;
        gyA[NF][r][c] = 0;
        gtA[NF][r][c] = 0;
      end
    end

    // R1: outputs quiet during reset
    repeat (2) @(negedge clk);
    checkOn = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (tensXX !== 0 || tensYY !== 0 || tensTT !== 0 || tensXY !== 0 || tensXT !== 0 || tensYT !== 0) begin
      fails++;
      $display("FAIL R1 outputs after reset got %0d %0d %0d %0d %0d %0d expected all 0",
               tensXX, tensYY, tensTT, tensXY, tensXT, tensYT);
    end

    for (int f = 0; f < NF; f++)
      for (int r = 0; r < TH; r++)
        for (int c = 0; c < TW; c++)
          drivePix(f, r, c);
    // flush: R8 releases the last row of the final frame
    for (int i = 0; i <= TW; i++) drivePix(NF, i / TW, i % TW);
    @(negedge clk);
    inValid = 1'b0;
    repeat (12) @(negedge clk);

    checks++;
    if (qExp.size() != 0) begin
      fails++;
      $display("FAIL R6 pending results got %0d expected 0", qExp.size());
    end
    done = 1'b1;
    finishRun();
  end

endmodule